// File: doc/BRIEF.md
# Floating-Point Compare to Integer Flags Unit

This block compares two 80-bit double-extended floating-point values: the top of the register stack and a second stack entry. It reduces the result to three integer status flags (zero, parity and carry), and it reports the invalid-operation, stack-fault and denormal-operand conditions that the comparison raises. A caller presents both operands together with their empty indications, the compare mode, the invalid-operation mask and a pop request, and pulses `start` for one cycle.

Each operand is first decoded into a class: zero, denormal, normal, infinity, quiet NaN, signalling NaN or unsupported. Ordered operands are then compared by sign and magnitude. The class information decides whether the flags are written, whether an exception is raised and whether the stack pops. The flag triple sits in a register. When an unmasked invalid-operation exception suppresses the write, the register keeps the value it had before.

The datapath is combinational, and a single register stage follows it. Every result appears in the cycle after the start pulse.

Top module: `fcmp_flags`

## Requirements
- R1: Output `flags` carries ZF in bit 2, PF in bit 1 and CF in bit 0. For two ordered operands the value is 3'b000 when `op_a` is greater than `op_b`, 3'b001 when it is less, and 3'b100 when the two are equal. In each case `flag_we` is 1.
- R2: Ordered operands compare by sign and magnitude, which includes negative values and infinities. +0 and -0 compare as equal.
- R3: Operand fields are laid out as follows: sign in bit 79, exponent in bits 78:64, explicit integer bit in bit 63, fraction in bits 62:0. An exponent of all ones with integer bit 1 and a zero fraction is an infinity. With integer bit 1 and fraction bit 62 set, it is a quiet NaN. With integer bit 1, fraction bit 62 clear and a nonzero fraction, it is a signalling NaN. Any nonzero exponent with integer bit 0 is unsupported.
- R4: When `unord_mode` is 0, a NaN of either kind or an unsupported operand raises `exc_ie`.
- R5: When `unord_mode` is 1, a quiet NaN alone does not raise `exc_ie`, and the flags are written to 3'b111. A signalling NaN or an unsupported operand still raises `exc_ie`.
- R6: When `exc_ie` is raised and `inv_mask` is 1, the flags are written to 3'b111. When `exc_ie` is raised and `inv_mask` is 0, `flag_we` is 0 and `flags` keeps its previous value.
- R7: If `a_empty` or `b_empty` is set, `exc_ie` and `exc_sf` are both raised, whatever the operand contents. Flag handling then follows R6.
- R8: A denormal operand, meaning a zero exponent with a nonzero mantissa, raises `exc_de` when no invalid-operation exception is raised. An operand that raises `exc_ie` leaves `exc_de` at 0.
- R9: `cc_c1` is 0 after every compare, stack underflow included.
- R10: `pop_stb` pulses when `pop_req` was set and the flags were written. It stays 0 when an unmasked invalid-operation exception suppresses the write.
- R11: All results appear one cycle after `start`. `res_valid`, `flag_we` and `pop_stb` are single-cycle pulses. Without `start`, `flags` and the exception bits hold their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to compare |
| op_a | input | 80 | Stack-top operand |
| op_b | input | 80 | Other stack operand |
| a_empty | input | 1 | Stack-top entry is empty |
| b_empty | input | 1 | Other entry is empty |
| unord_mode | input | 1 | 1 = quiet NaNs do not raise invalid |
| inv_mask | input | 1 | Invalid-operation exception mask |
| pop_req | input | 1 | Popping variant of the compare |
| flags | output | 3 | {ZF, PF, CF} |
| flag_we | output | 1 | Flags were written by this compare |
| exc_ie | output | 1 | Invalid-operation exception |
| exc_sf | output | 1 | Stack fault (underflow) |
| exc_de | output | 1 | Denormal-operand exception |
| cc_c1 | output | 1 | C1 condition bit |
| pop_stb | output | 1 | Pop the register stack |
| res_valid | output | 1 | Result of the last start is present |

## Verification
Every output of this block comes one register after the start pulse. The flag triple, the three exception bits, C1 and the pop strobe are all due in the cycle that follows the edge on which `start` is sampled. The bench drives each request on a falling edge and lowers `start` on the next falling edge. It reads every output at that second falling edge, half a cycle after the register has loaded. Hold behaviour is checked by reading the same outputs again after several idle cycles. The expected flags for a suppressed write are tracked as the last value the bench expected to be written.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int EXP_W = 15;
    localparam int MAN_W = 64;
    localparam int FP_W  = 1 + EXP_W + MAN_W;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DENORM,
        CL_NORMAL,
        CL_INF,
        CL_QNAN,
        CL_SNAN,
        CL_UNSUP
    } fp_class_e;

    // Flag triple {ZF, PF, CF}
    localparam logic [2:0] FL_GT = 3'b000;
    localparam logic [2:0] FL_LT = 3'b001;
    localparam logic [2:0] FL_EQ = 3'b100;
    localparam logic [2:0] FL_UN = 3'b111;

    typedef struct packed {
        logic [2:0] flags;
        logic       flag_we;
        logic       ie;
        logic       sf;
        logic       de;
        logic       c1;
        logic       pop;
        logic       valid;
    } cmp_out_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W
) (
    input  logic [EW+MW:0] opnd,
    output fp_class_e      cls
);
    localparam int FW = MW - 1;

    logic [EW-1:0] exp_f;
    logic          int_bit;
    logic [FW-1:0] frac;
    logic          exp_zero;
    logic          exp_ones;

    assign exp_f    = opnd[EW+MW-1 -: EW];
    assign int_bit  = opnd[MW-1];
    assign frac     = opnd[FW-1:0];
    assign exp_zero = (exp_f == '0);
    assign exp_ones = (exp_f == '1);

    always_comb begin
        if (exp_zero) begin
            cls = ({int_bit, frac} == '0) ? CL_ZERO : CL_DENORM;
        end else if (!int_bit) begin
            cls = CL_UNSUP;
        end else if (exp_ones) begin
            if (frac == '0)        cls = CL_INF;
            else if (frac[FW-1])   cls = CL_QNAN;
            else                   cls = CL_SNAN;
        end else begin
            cls = CL_NORMAL;
        end
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int W = 80
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         both_zero,
    output logic         lt,
    output logic         eq
);
    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         mag_gt, mag_eq;

    assign sa     = a[W-1];
    assign sb     = b[W-1];
    assign ma     = a[W-2:0];
    assign mb     = b[W-2:0];
    assign mag_gt = (ma > mb);
    assign mag_eq = (ma == mb);

    always_comb begin
        if (both_zero) begin
            eq = 1'b1;
            lt = 1'b0;
        end else if (sa != sb) begin
            eq = 1'b0;
            lt = sa;
        end else begin
            eq = mag_eq;
            lt = !mag_eq && (sa ? mag_gt : !mag_gt);
        end
    end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EW+MW:0]   op_a,
    input  logic [EW+MW:0]   op_b,
    input  logic             a_empty,
    input  logic             b_empty,
    input  logic             unord_mode,
    input  logic             inv_mask,
    input  logic             pop_req,
    output logic [2:0]       flags,
    output logic             flag_we,
    output logic             exc_ie,
    output logic             exc_sf,
    output logic             exc_de,
    output logic             cc_c1,
    output logic             pop_stb,
    output logic             res_valid
);
    localparam int W    = EW + MW + 1;
    localparam int NOPS = 2;

    logic [W-1:0] opnd [NOPS];
    fp_class_e    cls  [NOPS];
    logic [NOPS-1:0] is_zero, is_den, is_qnan, is_snan, is_unsup;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fcmp_classify #(.EW(EW), .MW(MW)) u_cls (
            .opnd (opnd[i]),
            .cls  (cls[i])
        );
        assign is_zero[i]  = (cls[i] == CL_ZERO);
        assign is_den[i]   = (cls[i] == CL_DENORM);
        assign is_qnan[i]  = (cls[i] == CL_QNAN);
        assign is_snan[i]  = (cls[i] == CL_SNAN);
        assign is_unsup[i] = (cls[i] == CL_UNSUP);
    end

    logic ord_lt, ord_eq;

    fcmp_order #(.W(W)) u_ord (
        .a         (op_a),
        .b         (op_b),
        .both_zero (&is_zero),
        .lt        (ord_lt),
        .eq        (ord_eq)
    );

    cmp_out_t res_d, res_q;

    logic       underflow, bad_nan, unordered, raise_ie, do_write;
    logic [2:0] cmp_val;

    always_comb begin
        underflow = a_empty | b_empty;
        unordered = |(is_qnan | is_snan | is_unsup);
        bad_nan   = |(is_snan | is_unsup) | (!unord_mode & |is_qnan);
        raise_ie  = underflow | bad_nan;
        do_write  = !raise_ie | inv_mask;

        if (raise_ie || unordered) cmp_val = FL_UN;
        else if (ord_eq)           cmp_val = FL_EQ;
        else if (ord_lt)           cmp_val = FL_LT;
        else                       cmp_val = FL_GT;

        res_d         = res_q;
        res_d.valid   = 1'b0;
        res_d.flag_we = 1'b0;
        res_d.pop     = 1'b0;

        if (start) begin
            res_d.valid   = 1'b1;
            res_d.flag_we = do_write;
            res_d.ie      = raise_ie;
            res_d.sf      = underflow;
            res_d.de      = !raise_ie & |is_den;
            res_d.c1      = 1'b0;
            res_d.pop     = pop_req & do_write;
            if (do_write) res_d.flags = cmp_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign flags     = res_q.flags;
    assign flag_we   = res_q.flag_we;
    assign exc_ie    = res_q.ie;
    assign exc_sf    = res_q.sf;
    assign exc_de    = res_q.de;
    assign cc_c1     = res_q.c1;
    assign pop_stb   = res_q.pop;
    assign res_valid = res_q.valid;
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       inv_mask,
    input logic       pop_req,
    input logic [2:0] flags,
    input logic       flag_we,
    input logic       exc_ie,
    input logic       exc_sf,
    input logic       exc_de,
    input logic       cc_c1,
    input logic       pop_stb,
    input logic       res_valid
);
    p_valid_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);
    p_no_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid);
    p_we_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> res_valid);
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |-> flags == $past(flags));
    p_ie_masked_unord_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && exc_ie && flag_we) |-> flags == 3'b111);
    p_ie_unmasked_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !inv_mask) |=> (!exc_ie || !flag_we));
    p_sf_with_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_sf |-> exc_ie);
    p_de_excl_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_de |-> !exc_ie);
    p_c1_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cc_c1);
    p_pop_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stb |-> (flag_we && $past(pop_req)));
endmodule

bind fcmp_flags fcmp_flags_chk u_chk (.*);

// File: tb/sim_fcmp_flags.sv
`timescale 1ns/1ps
module sim_fcmp_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] op_a = '0, op_b = '0;
    logic        a_empty = 1'b0, b_empty = 1'b0;
    logic        unord_mode = 1'b0, inv_mask = 1'b0, pop_req = 1'b0;
    logic [2:0]  flags;
    logic        flag_we, exc_ie, exc_sf, exc_de, cc_c1, pop_stb, res_valid;

    always #2 clk = ~clk;

    fcmp_flags u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .a_empty(a_empty), .b_empty(b_empty), .unord_mode(unord_mode),
        .inv_mask(inv_mask), .pop_req(pop_req), .flags(flags), .flag_we(flag_we),
        .exc_ie(exc_ie), .exc_sf(exc_sf), .exc_de(exc_de), .cc_c1(cc_c1),
        .pop_stb(pop_stb), .res_valid(res_valid)
    );

    // Encodings per R3: sign 79, exponent 78:64, integer bit 63, fraction 62:0
    localparam logic [79:0] POS1  = {1'b0, 15'h3FFF, 1'b1, 63'h0};
    localparam logic [79:0] POS2  = {1'b0, 15'h4000, 1'b1, 63'h0};
    localparam logic [79:0] NEG1  = {1'b1, 15'h3FFF, 1'b1, 63'h0};
    localparam logic [79:0] NEG2  = {1'b1, 15'h4000, 1'b1, 63'h0};
    localparam logic [79:0] PZ    = 80'h0;
    localparam logic [79:0] NZ    = {1'b1, 79'h0};
    localparam logic [79:0] PINF  = {1'b0, 15'h7FFF, 1'b1, 63'h0};
    localparam logic [79:0] NINF  = {1'b1, 15'h7FFF, 1'b1, 63'h0};
    localparam logic [79:0] QNAN  = {1'b0, 15'h7FFF, 2'b11, 62'h0};
    localparam logic [79:0] SNAN  = {1'b0, 15'h7FFF, 2'b10, 62'h1};
    localparam logic [79:0] UNSUP = {1'b0, 15'h3FFF, 1'b0, 63'h5};
    localparam logic [79:0] UNINF = {1'b0, 15'h7FFF, 1'b0, 63'h0};
    localparam logic [79:0] DEN   = {1'b0, 15'h0000, 1'b0, 63'h1};

    typedef struct packed {
        logic [79:0] a;
        logic [79:0] b;
        logic        ae, be, um, mk, pp;
        logic [2:0]  fl;
        logic        we, ie, sf, de, pop;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        //  a      b     ae    be    um    mk    pp    fl      we    ie    sf    de    pop   req
        '{POS2,  POS1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 gt
        '{POS1,  POS2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 lt
        '{POS1,  POS1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 eq
        '{NEG1,  POS1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 sign
        '{NEG2,  NEG1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 negatives
        '{PZ,    NZ,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 +0 = -0
        '{PINF,  POS2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 inf
        '{NINF,  NEG2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 -inf
        '{QNAN,  POS1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 qnan ordered
        '{QNAN,  POS1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 qnan quiet
        '{POS1,  SNAN, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 snan
        '{UNSUP, POS1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 unsupported
        '{UNINF, POS1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 pseudo-inf
        '{DEN,   PZ,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 denormal
        '{POS1,  POS2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 pop
        '{POS1,  POS1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 eq, unmasked
        '{SNAN,  POS1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 hold, R10 no pop
        '{POS1,  POS2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 empty masked
        '{POS2,  POS1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 gt
        '{DEN,   POS1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 empty unmasked
        '{QNAN,  POS1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 mask unused
        '{DEN,   QNAN, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8}   // R8 no DE with IE
    };

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [2:0] last_fl = 3'b000;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        op_a = v.a; op_b = v.b; a_empty = v.ae; b_empty = v.be;
        unord_mode = v.um; inv_mask = v.mk; pop_req = v.pp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check({flags, flag_we, exc_ie, exc_sf, exc_de, cc_c1, pop_stb, res_valid} == '0,
              "R11 reset", {6'h0, flags, flag_we, exc_ie, exc_sf, exc_de, cc_c1, pop_stb, res_valid}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] ef;
            string      tag;
            issue(VECS[i]);
            ef  = VECS[i].we ? VECS[i].fl : last_fl;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check(flags === ef, {tag, " flags"}, {13'h0, flags}, {13'h0, ef});
            // bundle: we ie sf de pop c1(R9) valid(R11)
            check({flag_we, exc_ie, exc_sf, exc_de, pop_stb, cc_c1, res_valid} ===
                  {VECS[i].we, VECS[i].ie, VECS[i].sf, VECS[i].de, VECS[i].pop, 1'b0, 1'b1},
                  {tag, " status"},
                  {9'h0, flag_we, exc_ie, exc_sf, exc_de, pop_stb, cc_c1, res_valid},
                  {9'h0, VECS[i].we, VECS[i].ie, VECS[i].sf, VECS[i].de, VECS[i].pop, 1'b0, 1'b1});
            last_fl = ef;
        end

        // R11 hold: idle cycles keep flags and exception bits, strobes low
        issue('{POS1, NEG1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11});
        check(flags === 3'b000 && pop_stb === 1'b1, "R11 gt with pop", {12'h0, flags, pop_stb}, 16'h1);
        op_a = SNAN; a_empty = 1'b1; pop_req = 1'b1;
        repeat (3) @(negedge clk);
        check({res_valid, flag_we, pop_stb} === 3'b000, "R11 strobes idle",
              {13'h0, res_valid, flag_we, pop_stb}, 16'h0);
        check(flags === 3'b000 && exc_ie === 1'b0, "R11 hold idle", {12'h0, flags, exc_ie}, 16'h0);

        // R7 empty entry overrides operand contents; R9 C1 cleared on underflow
        issue('{POS2, POS1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7});
        check({flags, exc_ie, exc_sf, cc_c1} === 6'b111110, "R7 R9 underflow",
              {10'h0, flags, exc_ie, exc_sf, cc_c1}, 16'h3E);

        // R6 unmasked invalid right after an unordered write keeps 111
        issue('{SNAN, SNAN, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6});
        check(flags === 3'b111 && flag_we === 1'b0, "R6 hold unordered",
              {12'h0, flags, flag_we}, 16'hE);

        // R11 back-to-back starts each produce a pulse
        @(negedge clk);
        op_a = POS1; op_b = POS2; a_empty = 1'b0; b_empty = 1'b0; inv_mask = 1'b1; pop_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b1 && flags === 3'b001, "R11 back-to-back 1", {12'h0, flags, res_valid}, 16'h3);
        op_a = POS2; op_b = POS1;
        @(negedge clk);
        start = 1'b0;
        check(res_valid === 1'b1 && flags === 3'b000, "R11 back-to-back 2", {12'h0, flags, res_valid}, 16'h1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule